// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Switch

This block routes seventeen single-bit lanes onto seventeen output lanes. Every output has its own 17:1 selector, so an output takes exactly one input while one input may feed any number of outputs. The lane data path has no registers; only the selector settings are clocked.

A small parallel host port programs the selectors. Writes go into a staging bank. A configure strobe then moves the whole staging bank into the active bank at once, so a full reconfiguration changes every output on the same clock edge. If the configure strobe is held high, the active bank follows the staging bank and each write takes effect at once. The host can read back any staged selector.

The port strobes arrive from outside the clock domain. They pass through two synchronizer flops and are then edge-detected. An address-latch input supports hosts that share address and data on one bus.

Top module: `xpt_route_switch`

## Requirements
- R1: Each output lane equals the input lane named by its active selector. Several outputs may name the same input at the same time.
- R2: The register number is a 6-bit binary value on `bus_addr`, and registers 0 to 16 map to outputs 0 to 16. The selector is a 5-bit binary input number on `bus_wdata`. A write to any register from 17 to 63 changes no staged or active selector.
- R3: A staged selector is updated when `wr_n` rises while `cs_n` is low. The update completes on the third clock edge after the rise. A `wr_n` pulse while `cs_n` is high changes nothing.
- R4: While `cfg_strobe` is low, writes do not change the routing. Raising `cfg_strobe` while `cs_n` is low copies all seventeen staged selectors into the active bank together. Raising `cfg_strobe` while `cs_n` is high has no effect.
- R5: While `cfg_strobe` is high and `cs_n` is low, the active bank tracks the staging bank, so a write changes the routing with no separate configure pulse.
- R6: While `cs_n` and `rd_n` are both low and the register number is 0 to 16, `bus_rdata_en` is high and `bus_rdata` carries that output's staged selector. Otherwise `bus_rdata_en` is low and `bus_rdata` is zero.
- R7: While `addr_latch_en` is high, the register number follows `bus_addr`. While it is low, the last value seen with it high is used.
- R8: A selector value from 17 to 31 is stored and read back unchanged, but it forces its output lane low.
- R9: After reset, both banks hold 0, so every output follows input 0, and the read bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 17 | Input lanes |
| lane_out | output | 17 | Output lanes |
| bus_addr | input | 6 | Register number (output index) |
| addr_latch_en | input | 1 | High: address follows bus; low: held address used |
| bus_wdata | input | 5 | Selector value to write |
| bus_rdata | output | 5 | Read-back selector value |
| bus_rdata_en | output | 1 | High while the read bus is driven |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, acts on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| cfg_strobe | input | 1 | Configure: copy staging bank to active bank |

## Verification
The hardest case to reach is transparent mode: chip select and configure must both stay asserted across a whole write cycle, while the write strobe toggles underneath them. The bench has a write task that can leave chip select low, and it checks the routing straight after the write with no configure pulse in between. A second hard case is a configure pulse with chip select high. The bench drives it on purpose after staging a change, then confirms that the lanes still follow the old selectors.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int unsigned XPT_LANES  = 17;
    localparam int unsigned XPT_SEL_W  = 5;
    localparam int unsigned XPT_ADDR_W = 6;

    // one sample of the host-port strobes, raw levels
    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic cs_n;
        logic cfg;
    } port_strobe_t;

    localparam port_strobe_t STROBE_IDLE = '{wr_n: 1'b1, rd_n: 1'b1, cs_n: 1'b1, cfg: 1'b0};
endpackage

// File: rtl/xpt_strobe_sync.sv
module xpt_strobe_sync
    import xpt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic cs_n,
    input  logic cfg,
    output logic write_fire,
    output logic read_active,
    output logic commit
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        port_strobe_t [SYNC_STAGES-1:0] chain;
        logic                           wr_prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    port_strobe_t raw_s, settled_s;
    logic selected;

    always_comb begin
        raw_s      = '{wr_n: wr_n, rd_n: rd_n, cs_n: cs_n, cfg: cfg};
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], raw_s};
        st_d.wr_prev = st_q.chain[LAST].wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain   <= {SYNC_STAGES{STROBE_IDLE}};
            st_q.wr_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        settled_s   = st_q.chain[LAST];
        selected    = ~settled_s.cs_n;
        write_fire  = selected & settled_s.wr_n & ~st_q.wr_prev;
        read_active = selected & ~settled_s.rd_n;
        commit      = selected & settled_s.cfg;
    end

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        write_fire |=> !write_fire); // R3

    AST_WRITE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        write_fire |-> !st_q.chain[LAST].cs_n); // R3
endmodule

// File: rtl/xpt_addr_hold.sv
module xpt_addr_hold
    import xpt_pkg::*;
#(
    parameter int unsigned ADDR_W = XPT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (latch_en) st_d.held = bus_addr;
        eff_addr = latch_en ? bus_addr : st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && $past(!latch_en)) |-> $stable(eff_addr)); // R7
endmodule

// File: rtl/xpt_sel_banks.sv
module xpt_sel_banks
    import xpt_pkg::*;
#(
    parameter int unsigned N_OUT  = XPT_LANES,
    parameter int unsigned SEL_W  = XPT_SEL_W,
    parameter int unsigned ADDR_W = XPT_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        write_fire,
    input  logic                        read_active,
    input  logic                        commit,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [SEL_W-1:0]            wdata,
    output logic [N_OUT-1:0][SEL_W-1:0] active_sel,
    output logic [SEL_W-1:0]            rdata,
    output logic                        rdata_en
);
    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] stage;
        logic [N_OUT-1:0][SEL_W-1:0] active;
        logic [SEL_W-1:0]            rdata;
        logic                        drive;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        addr_hit;
    logic [SEL_W-1:0] stage_at_addr;

    always_comb begin
        st_d          = st_q;
        addr_hit      = 1'b0;
        stage_at_addr = '0;
        for (int o = 0; o < int'(N_OUT); o++) begin
            if (addr == ADDR_W'(o)) begin
                addr_hit      = 1'b1;
                stage_at_addr = st_q.stage[o];
                if (write_fire) st_d.stage[o] = wdata;
            end
        end
        if (commit) st_d.active = st_d.stage;
        st_d.drive = read_active & addr_hit;
        st_d.rdata = (read_active & addr_hit) ? stage_at_addr : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_sel = st_q.active;
    assign rdata      = st_q.rdata;
    assign rdata_en   = st_q.drive;

    AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !write_fire |=> $stable(st_q.stage)); // R3

    AST_ACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.active)); // R4

    AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.active == st_q.stage)); // R5

    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_en |-> (rdata == '0)); // R6
endmodule

// File: rtl/xpt_lane_mux.sv
module xpt_lane_mux
    import xpt_pkg::*;
#(
    parameter int unsigned N_IN  = XPT_LANES,
    parameter int unsigned SEL_W = XPT_SEL_W
) (
    input  logic [N_IN-1:0]  lanes,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < int'(N_IN); i++) begin
            if (sel == SEL_W'(i)) y = lanes[i];
        end
    end
endmodule

// File: rtl/xpt_route_switch.sv
module xpt_route_switch
    import xpt_pkg::*;
#(
    parameter int unsigned N_LANES     = XPT_LANES,
    parameter int unsigned SEL_W       = XPT_SEL_W,
    parameter int unsigned ADDR_W      = XPT_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LANES-1:0] lane_in,
    output logic [N_LANES-1:0] lane_out,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               addr_latch_en,
    input  logic [SEL_W-1:0]   bus_wdata,
    output logic [SEL_W-1:0]   bus_rdata,
    output logic               bus_rdata_en,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic               rd_n,
    input  logic               cfg_strobe
);
    logic                          write_fire;
    logic                          read_active;
    logic                          commit;
    logic [ADDR_W-1:0]             eff_addr;
    logic [N_LANES-1:0][SEL_W-1:0] active_sel;

    xpt_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .cs_n       (cs_n),
        .cfg        (cfg_strobe),
        .write_fire (write_fire),
        .read_active(read_active),
        .commit     (commit)
    );

    xpt_addr_hold #(.ADDR_W(ADDR_W)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_en(addr_latch_en),
        .bus_addr(bus_addr),
        .eff_addr(eff_addr)
    );

    xpt_sel_banks #(.N_OUT(N_LANES), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) banks_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .write_fire (write_fire),
        .read_active(read_active),
        .commit     (commit),
        .addr       (eff_addr),
        .wdata      (bus_wdata),
        .active_sel (active_sel),
        .rdata      (bus_rdata),
        .rdata_en   (bus_rdata_en)
    );

    for (genvar o = 0; o < N_LANES; o++) begin : g_out
        xpt_lane_mux #(.N_IN(N_LANES), .SEL_W(SEL_W)) mux_i (
            .lanes(lane_in),
            .sel  (active_sel[o]),
            .y    (lane_out[o])
        );

        AST_OVERRANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (active_sel[o] >= SEL_W'(N_LANES)) |-> !lane_out[o]); // R8
    end
endmodule

// File: tb/xpt_route_switch_tb.sv
`timescale 1ns/1ps
module xpt_route_switch_tb_top;
    localparam int NL = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] lane_in = '0;
    logic [16:0] lane_out;
    logic [5:0]  bus_addr = '0;
    logic        addr_latch_en = 1'b1;
    logic [4:0]  bus_wdata = '0;
    logic [4:0]  bus_rdata;
    logic        bus_rdata_en;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        cfg_strobe = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int exp_stage [NL];
    int exp_act   [NL];

    always #5 clk = ~clk;

    xpt_route_switch dut_i (
        .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .lane_out(lane_out),
        .bus_addr(bus_addr), .addr_latch_en(addr_latch_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en), .cs_n(cs_n),
        .wr_n(wr_n), .rd_n(rd_n), .cfg_strobe(cfg_strobe)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_routes(string req);
        logic [16:0] pats [4];
        pats[0] = 17'h15A5C; pats[1] = 17'h0A3B1; pats[2] = 17'h1FFFF; pats[3] = 17'h00001;
        for (int p = 0; p < 4; p++) begin
            logic [16:0] e;
            lane_in = pats[p];
            #1;
            for (int o = 0; o < NL; o++)
                e[o] = (exp_act[o] < NL) ? pats[p][exp_act[o]] : 1'b0;
            check(req, int'(lane_out), int'(e));
            cycles(1);
        end
    endtask

    task automatic bus_write(int a, int d, bit keep_cs);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = 5'(d); cs_n = 1'b0;
        cycles(2);
        wr_n = 1'b0;
        cycles(4);
        wr_n = 1'b1;
        cycles(5);
        if (!keep_cs) cs_n = 1'b1;
        cycles(3);
        if (a < NL) begin
            exp_stage[a] = d;
            if (keep_cs && cfg_strobe) exp_act[a] = d;
        end
    endtask

    task automatic bus_configure();
        @(negedge clk);
        cs_n = 1'b0; cfg_strobe = 1'b1;
        cycles(4);
        cfg_strobe = 1'b0;
        cycles(1);
        cs_n = 1'b1;
        cycles(3);
        for (int o = 0; o < NL; o++) exp_act[o] = exp_stage[o];
    endtask

    task automatic bus_read(int a, output int d, output int en);
        @(negedge clk);
        bus_addr = 6'(a); cs_n = 1'b0; rd_n = 1'b0;
        cycles(5);
        d = int'(bus_rdata); en = int'(bus_rdata_en);
        rd_n = 1'b1; cs_n = 1'b1;
        cycles(4);
    endtask

    task automatic t_reset();
        int d, en;
        check("R9 idle drive", int'(bus_rdata_en), 0);
        check("R9 idle data", int'(bus_rdata), 0);
        check_routes("R9 routes to input 0");
        bus_read(4, d, en);
        check("R9 staged zero", d, 0);
    endtask

    task automatic t_staged_commit();
        int d, en;
        for (int o = 0; o < NL; o++) bus_write(o, (o * 5 + 3) % NL, 0);
        check_routes("R4 no change before configure");
        bus_read(4, d, en);
        check("R6 read enable", en, 1);
        check("R2 R6 readback addr 4", d, 6);
        bus_read(16, d, en);
        check("R6 readback last output", d, (16 * 5 + 3) % NL);
        bus_configure();
        check_routes("R1 R4 all committed");
    endtask

    task automatic t_fanout();
        bus_write(3, 9, 0); bus_write(7, 9, 0); bus_write(11, 9, 0);
        bus_configure();
        lane_in = 17'h00200; #1;
        check("R1 fanout out3", int'(lane_out[3]), 1);
        check("R1 fanout out7", int'(lane_out[7]), 1);
        check("R1 fanout out11", int'(lane_out[11]), 1);
        check_routes("R1 fanout");
    endtask

    task automatic t_cfg_without_cs();
        bus_write(0, 12, 0);
        @(negedge clk);
        cfg_strobe = 1'b1; cycles(5); cfg_strobe = 1'b0; cycles(4);
        check_routes("R4 configure ignored without select");
        bus_configure();
        check_routes("R4 later configure");
    endtask

    task automatic t_write_without_cs();
        int d, en;
        @(negedge clk);
        bus_addr = 6'd2; bus_wdata = 5'd1;
        cycles(2); wr_n = 1'b0; cycles(4); wr_n = 1'b1; cycles(5);
        bus_read(2, d, en);
        check("R3 write ignored without select", d, exp_stage[2]);
        bus_configure();
        check_routes("R3 routing unchanged");
    endtask

    task automatic t_bad_addr();
        int d, en;
        bus_write(17, 3, 0);
        bus_write(63, 4, 0);
        bus_configure();
        check_routes("R2 high register writes ignored");
        bus_read(17, d, en);
        check("R6 no drive above 16", en, 0);
        check("R6 zero data above 16", d, 0);
    endtask

    task automatic t_overrange();
        int d, en;
        bus_write(5, 20, 0);
        bus_configure();
        lane_in = 17'h1FFFF; #1;
        check("R8 overrange output low", int'(lane_out[5]), 0);
        check_routes("R8 other outputs");
        bus_read(5, d, en);
        check("R8 overrange readback", d, 20);
    endtask

    task automatic t_transparent();
        @(negedge clk);
        cs_n = 1'b0; cfg_strobe = 1'b1;
        cycles(4);
        for (int o = 0; o < NL; o++) exp_act[o] = exp_stage[o];
        bus_write(8, 13, 1);
        check_routes("R5 transparent write");
        bus_write(1, 0, 1);
        check_routes("R5 second transparent write");
        cfg_strobe = 1'b0; cycles(1); cs_n = 1'b1; cycles(3);
    endtask

    task automatic t_addr_latch();
        int d, en;
        @(negedge clk);
        addr_latch_en = 1'b1; bus_addr = 6'd10;
        cycles(2);
        addr_latch_en = 1'b0; bus_addr = 6'd1; bus_wdata = 5'd4; cs_n = 1'b0;
        cycles(2); wr_n = 1'b0; cycles(4); wr_n = 1'b1; cycles(5);
        cs_n = 1'b1; cycles(3);
        addr_latch_en = 1'b1;
        exp_stage[10] = 4;
        bus_read(10, d, en);
        check("R7 latched address written", d, 4);
        bus_read(1, d, en);
        check("R7 bus address not written", d, exp_stage[1]);
    endtask

    initial begin
        for (int o = 0; o < NL; o++) begin exp_stage[o] = 0; exp_act[o] = 0; end
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_staged_commit();
        t_fanout();
        t_cfg_without_cs();
        t_write_without_cs();
        t_bad_addr();
        t_overrange();
        t_transparent();
        t_addr_latch();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule